// File: doc/BRIEF.md
# Decode-Stage Branch Resolver

This block produces the next fetch address for a five-stage in-order pipeline whose conditional branches are decided during instruction decode instead of during execute. The decode stage supplies four things: the incremented address of the branch (its PC+4), the raw 16-bit offset field, the two register operand values, and a two-bit branch kind. The block answers in the same cycle with a taken flag and the next fetch address. It also holds the fetch program counter register, which it updates from that next address on every cycle that is not stalled.

The comparison is only an equal/not-equal test on the two operands. A small target adder placed in decode is therefore enough to resolve a branch one stage after fetch. The one remaining cycle of penalty is exposed to software as a single delay slot. The instruction fetched while the branch sits in decode always executes, and nothing is ever flushed. A stall from the hazard unit freezes the program counter and blocks any redirection in that cycle. Instruction memory, the register file and any prediction logic sit outside the block.

Top module: `branch_resolver`

## Requirements
- R1: While reset is high, and in the first cycle after reset is released, the fetch PC equals the reset vector parameter (default 0x0000_0000).
- R2: Branch kind code 2'b01 (branch-if-equal) sets taken when the two operands are identical and stall is low.
- R3: Branch kind code 2'b10 (branch-if-not-equal) sets taken when the two operands differ and stall is low.
- R4: Branch kind codes 2'b00 (no branch) and 2'b11 (reserved) never set taken, whatever the operand values are.
- R5: The branch target is the decode PC+4 plus the 16-bit offset, sign-extended to 32 bits and shifted left by two, taken modulo 2^32.
- R6: When taken is set, next PC equals the branch target. The fetch PC shows that target after the next clock edge. The fetch PC shown in the resolving cycle (the delay slot address) is not altered.
- R7: When neither stall nor taken is set, next PC equals the current fetch PC plus 4, and the fetch PC takes that value at the next edge.
- R8: When stall is high, taken is low, next PC equals the current fetch PC, and the fetch PC keeps its value across the edge, even if the branch condition holds.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| stall | input | 1 | Hazard-unit stall: hold PC, suppress redirect |
| dec_pc_plus4 | input | 32 | Incremented address of the instruction in decode |
| dec_imm | input | 16 | Raw branch offset field, in words |
| opnd_a | input | 32 | First register operand |
| opnd_b | input | 32 | Second register operand |
| br_kind | input | 2 | 00 none, 01 branch-if-equal, 10 branch-if-not-equal, 11 reserved |
| fetch_pc | output | 32 | Current fetch program counter |
| next_pc | output | 32 | Address the fetch PC takes at the next edge |
| taken | output | 1 | Branch in decode redirects fetch |

## Verification
The bench goes after the edges of the offset arithmetic. It uses the most negative and most positive offsets and a target that wraps past the top of the address space. A design that forgot the sign extension or the shift by two would send fetch to a wildly wrong address. It also drives a stall in a cycle whose branch condition holds. A design that let the redirect through would lose the target or skip the stalled instruction. Finally, it feeds the reserved kind code and the equal/not-equal codes with operands that differ in one bit only. Swapping the sense of the comparison, or decoding the reserved code as a branch, shows up as a wrong taken flag and a wrong next fetch address.

// File: rtl/branch_resolver_pkg.sv
package branch_resolver_pkg;

    localparam int XLEN     = 32;
    localparam int OFF_W    = 16;
    localparam int WORD_SH  = 2;
    localparam int INSN_B   = 4;

    typedef enum logic [1:0] {
        BRK_NONE = 2'b00,
        BRK_EQ   = 2'b01,
        BRK_NE   = 2'b10,
        BRK_RSVD = 2'b11
    } br_kind_e;

    typedef struct packed {
        logic            redirect;
        logic [XLEN-1:0] target;
    } br_verdict_t;

    function automatic logic [XLEN-1:0] off_to_bytes(input logic [OFF_W-1:0] off);
        logic [XLEN-1:0] ext;
        ext = {{(XLEN-OFF_W){off[OFF_W-1]}}, off};
        return ext << WORD_SH;
    endfunction

    function automatic logic is_cond_branch(input br_kind_e k);
        return (k == BRK_EQ) || (k == BRK_NE);
    endfunction

endpackage

// File: rtl/br_zero_test.sv
module br_zero_test
    import branch_resolver_pkg::*;
#(
    parameter int W        = XLEN,
    parameter bit USE_SUB  = 1'b0
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic         is_zero
);
    logic [W-1:0] diff;

    generate
        if (USE_SUB) begin : g_sub
            assign diff = a - b;
        end else begin : g_xor
            assign diff = a ^ b;
        end
    endgenerate

    assign is_zero = ~|diff;
endmodule

// File: rtl/br_target_adder.sv
module br_target_adder
    import branch_resolver_pkg::*;
(
    input  logic [XLEN-1:0]  base,
    input  logic [OFF_W-1:0] off,
    output logic [XLEN-1:0]  target
);
    logic [XLEN-1:0] byte_off;

    always_comb begin
        byte_off = off_to_bytes(off);
        target   = base + byte_off;
    end
endmodule

// File: rtl/br_decide.sv
module br_decide
    import branch_resolver_pkg::*;
(
    input  br_kind_e         kind,
    input  logic             zero,
    input  logic             hold,
    input  logic [XLEN-1:0]  target,
    output br_verdict_t      verdict
);
    logic cond;

    always_comb begin
        unique case (kind)
            BRK_EQ:  cond = zero;
            BRK_NE:  cond = ~zero;
            default: cond = 1'b0;
        endcase
        verdict.redirect = cond & ~hold & is_cond_branch(kind);
        verdict.target   = target;
    end
endmodule

// File: rtl/pc_sequencer.sv
module pc_sequencer
    import branch_resolver_pkg::*;
#(
    parameter logic [XLEN-1:0] RESET_VEC = '0
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            hold,
    input  br_verdict_t     verdict,
    output logic [XLEN-1:0] pc_q,
    output logic [XLEN-1:0] pc_d
);
    localparam logic [XLEN-1:0] STEP = XLEN'(INSN_B);

    always_comb begin
        if (hold)
            pc_d = pc_q;
        else if (verdict.redirect)
            pc_d = verdict.target;
        else
            pc_d = pc_q + STEP;
    end

    always_ff @(posedge clk) begin
        if (rst)
            pc_q <= RESET_VEC;
        else
            pc_q <= pc_d;
    end
endmodule

// File: rtl/branch_resolver.sv
module branch_resolver
    import branch_resolver_pkg::*;
#(
    parameter logic [31:0] RESET_VEC   = 32'h0000_0000,
    parameter bit          SUB_COMPARE = 1'b0
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        stall,
    input  logic [31:0] dec_pc_plus4,
    input  logic [15:0] dec_imm,
    input  logic [31:0] opnd_a,
    input  logic [31:0] opnd_b,
    input  logic [1:0]  br_kind,
    output logic [31:0] fetch_pc,
    output logic [31:0] next_pc,
    output logic        taken
);
    logic            zero;
    logic [XLEN-1:0] tgt;
    br_verdict_t     verdict;
    br_kind_e        kind;

    assign kind = br_kind_e'(br_kind);

    br_zero_test #(.W(XLEN), .USE_SUB(SUB_COMPARE)) u_zero (
        .a       (opnd_a),
        .b       (opnd_b),
        .is_zero (zero)
    );

    br_target_adder u_tgt (
        .base   (dec_pc_plus4),
        .off    (dec_imm),
        .target (tgt)
    );

    br_decide u_dec (
        .kind    (kind),
        .zero    (zero),
        .hold    (stall),
        .target  (tgt),
        .verdict (verdict)
    );

    pc_sequencer #(.RESET_VEC(RESET_VEC)) u_pc (
        .clk     (clk),
        .rst     (rst),
        .hold    (stall),
        .verdict (verdict),
        .pc_q    (fetch_pc),
        .pc_d    (next_pc)
    );

    assign taken = verdict.redirect;
endmodule

// File: rtl/branch_resolver_chk.sv
module branch_resolver_chk #(
    parameter logic [31:0] RESET_VEC = 32'h0000_0000
) (
    input logic        clk,
    input logic        rst,
    input logic        stall,
    input logic [31:0] opnd_a,
    input logic [31:0] opnd_b,
    input logic [1:0]  br_kind,
    input logic [31:0] fetch_pc,
    input logic [31:0] next_pc,
    input logic        taken
);
    a_r1_reset_vector: assert property (@(posedge clk)
        $past(rst) |-> fetch_pc == RESET_VEC);

    a_r2_eq_taken: assert property (@(posedge clk) disable iff (rst)
        (br_kind == 2'b01 && opnd_a == opnd_b && !stall) |-> taken);

    a_r3_ne_taken: assert property (@(posedge clk) disable iff (rst)
        (br_kind == 2'b10 && opnd_a != opnd_b && !stall) |-> taken);

    a_r4_no_branch_kind: assert property (@(posedge clk) disable iff (rst)
        (br_kind == 2'b00 || br_kind == 2'b11) |-> !taken);

    a_r6_redirect_lands: assert property (@(posedge clk) disable iff (rst)
        taken |=> fetch_pc == $past(next_pc));

    a_r7_sequential: assert property (@(posedge clk) disable iff (rst)
        (!stall && !taken) |=> fetch_pc == $past(fetch_pc) + 32'd4);

    a_r8_stall_holds: assert property (@(posedge clk) disable iff (rst)
        stall |=> $stable(fetch_pc));

    a_r8_stall_blocks: assert property (@(posedge clk) disable iff (rst)
        stall |-> !taken);
endmodule

bind branch_resolver branch_resolver_chk #(.RESET_VEC(RESET_VEC)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .stall    (stall),
    .opnd_a   (opnd_a),
    .opnd_b   (opnd_b),
    .br_kind  (br_kind),
    .fetch_pc (fetch_pc),
    .next_pc  (next_pc),
    .taken    (taken)
);

// File: tb/branch_resolver_bench.sv
module branch_resolver_bench;
    localparam logic [31:0] RVEC = 32'h0000_0000;

    logic        clk = 1'b0;
    logic        rst;
    logic        stall;
    logic [31:0] dec_pc_plus4;
    logic [15:0] dec_imm;
    logic [31:0] opnd_a;
    logic [31:0] opnd_b;
    logic [1:0]  br_kind;
    logic [31:0] fetch_pc;
    logic [31:0] next_pc;
    logic        taken;

    int checks = 0;
    int fails  = 0;
    logic [31:0] exp_pc;
    bit done = 1'b0;

    always #4 clk = ~clk;

    branch_resolver #(.RESET_VEC(RVEC)) u_branch_resolver (
        .clk(clk), .rst(rst), .stall(stall), .dec_pc_plus4(dec_pc_plus4),
        .dec_imm(dec_imm), .opnd_a(opnd_a), .opnd_b(opnd_b), .br_kind(br_kind),
        .fetch_pc(fetch_pc), .next_pc(next_pc), .taken(taken)
    );

    function automatic logic ref_taken(logic [1:0] k, logic [31:0] a, logic [31:0] b, logic s);
        if (s) return 1'b0;
        if (k == 2'b01) return a == b;
        if (k == 2'b10) return a != b;
        return 1'b0;
    endfunction

    function automatic logic [31:0] ref_target(logic [31:0] p4, logic [15:0] imm);
        return p4 + {{14{imm[15]}}, imm, 2'b00};
    endfunction

    task automatic check32(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
        end
    endtask

    // Drive one decode cycle at the falling edge, check combinational outputs,
    // then check the registered PC one edge later.
    task automatic step(string req, logic [1:0] k, logic [31:0] a, logic [31:0] b,
                        logic [31:0] p4, logic [15:0] imm, logic s);
        logic        et;
        logic [31:0] en;
        br_kind = k; opnd_a = a; opnd_b = b;
        dec_pc_plus4 = p4; dec_imm = imm; stall = s;
        #1;
        et = ref_taken(k, a, b, s);
        en = s ? exp_pc : (et ? ref_target(p4, imm) : exp_pc + 32'd4);
        check32({req, " taken"}, {31'd0, taken}, {31'd0, et});
        check32({req, " next_pc"}, next_pc, en);
        @(negedge clk);
        exp_pc = en;
        check32({req, " fetch_pc"}, fetch_pc, exp_pc);
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        rst = 1'b1; stall = 1'b0; br_kind = 2'b00;
        opnd_a = '0; opnd_b = '0; dec_pc_plus4 = '0; dec_imm = '0;
        repeat (3) @(negedge clk);
        check32("R1 in reset", fetch_pc, RVEC);
        rst = 1'b0;
        #1;
        check32("R1 taken low", {31'd0, taken}, 32'd0);
        exp_pc = RVEC;
        check32("R1 first cycle", fetch_pc, RVEC);

        // directed corner cases
        step("R7 sequential", 2'b00, 32'd5, 32'd5, 32'h100, 16'h0010, 1'b0);
        step("R2 eq taken", 2'b01, 32'hDEAD_BEEF, 32'hDEAD_BEEF, 32'h0000_1004, 16'h0003, 1'b0);
        step("R6 target", 2'b00, 32'd0, 32'd1, 32'h0, 16'h0, 1'b0);
        step("R2 eq one-bit diff", 2'b01, 32'h8000_0000, 32'h0000_0000, 32'h2000, 16'h0004, 1'b0);
        step("R3 ne equal ops", 2'b10, 32'h1234, 32'h1234, 32'h2000, 16'h0004, 1'b0);
        step("R3 ne one-bit diff", 2'b10, 32'h0000_0001, 32'h0, 32'h0000_4000, 16'h8000, 1'b0);
        step("R5 max positive", 2'b01, 32'd7, 32'd7, 32'h0001_0000, 16'h7FFF, 1'b0);
        step("R5 wrap", 2'b10, 32'd1, 32'd2, 32'hFFFF_FFFC, 16'h0001, 1'b0);
        step("R5 negative", 2'b01, 32'd0, 32'd0, 32'h0000_0010, 16'hFFFF, 1'b0);
        step("R4 reserved kind", 2'b11, 32'd9, 32'd9, 32'h3000, 16'h0040, 1'b0);
        step("R4 none kind", 2'b00, 32'd9, 32'd8, 32'h3000, 16'h0040, 1'b0);
        step("R8 stall eq", 2'b01, 32'd4, 32'd4, 32'h5000, 16'h0100, 1'b1);
        step("R8 stall ne", 2'b10, 32'd4, 32'd3, 32'h5000, 16'h0100, 1'b1);
        step("R6 after stall", 2'b01, 32'd4, 32'd4, 32'h5000, 16'h0100, 1'b0);

        // constrained random
        for (int i = 0; i < 400; i++) begin
            logic [31:0] a, b, p4;
            logic [1:0]  k;
            a  = $urandom;
            b  = ($urandom_range(0, 1) == 0) ? a : (a ^ (32'd1 << $urandom_range(0, 31)));
            k  = 2'($urandom_range(0, 3));
            p4 = {$urandom, 2'b00};
            step("R2 R3 R6 R7 R8 random", k, a, b, p4, 16'($urandom),
                 ($urandom_range(0, 7) == 0));
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule